// File: doc/BRIEF.md
# Reload-Counter Digitally Controlled Oscillator

This block turns a digital control word into a clock by counting cycles of a fast reference clock. A free-running counter of the same width as the control word counts upward. On the cycle it holds its all-ones value, the block raises a one-cycle event and loads the counter from the control word. One output period therefore lasts `2^CW - ctrl_word` fast-clock cycles. A larger word gives a shorter period and a higher output frequency. The word at the middle of its range sets the nominal frequency.

The event flips a square-wave output. A divide-by-`DIV` stage then derives a slower clock from those events, and phase-error processing in a loop built around the oscillator runs on that slower clock. The control word is read only at reload, so a loop filter can update it at any time without cutting short the period already running.

Top module: `dco_reload`

## Requirements
- R1: While reset is held, `tick_o`, `osc_o` and `div_o` are all 0. Reset loads the counter with the centre code `2^(CW-1)` and clears the divider count. The first event therefore appears `2^(CW-1)` cycles after reset is released, counting the centre-code cycle as the first.
- R2: With a steady control word `C` in the range `0..2^CW-2`, consecutive events on `tick_o` are exactly `2^CW - C` clock cycles apart.
- R3: `tick_o` is high for exactly one clock cycle per event. It is never high in two consecutive cycles.
- R4: The control word is sampled only in the cycle in which `tick_o` is high. A change of `ctrl_word` in any other cycle does not alter the length of the period in progress.
- R5: A control word of all ones is clamped. The period that follows it lasts 2 cycles, the same as for all ones minus one.
- R6: `osc_o` inverts on the clock edge that ends each event cycle and holds its value in every other cycle. After `k` events, `osc_o` equals bit 0 of `k`.
- R7: `div_o` inverts on the event edge of every `DIV`-th event and holds otherwise. After `k` events, `div_o` equals `(k / DIV) mod 2`.
- R8: A control word of 0 gives the longest period, `2^CW` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast counting clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_word | input | CW | Frequency control code, sampled at reload |
| tick_o | output | 1 | One-cycle pulse on each oscillator event |
| osc_o | output | 1 | Oscillator square wave, inverted per event |
| div_o | output | 1 | Divided clock, inverted every DIV events |

## Verification
The bench builds the block with `CW = 6` and `DIV = 3`. The 6-bit word keeps the longest period at 64 cycles, so the clamp at the top code, the 64-cycle floor at code 0 and a run of short and long periods all fit within a few hundred cycles. The odd divide ratio of 3 makes the divided clock's inversion points fall on alternating parities of the event count, so an off-by-one in the divider cannot line up by chance with the oscillator output.

// File: rtl/dco_reload.sv
module dco_reload #(
  parameter int CW  = 8,
  parameter int DIV = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] ctrl_word,
  output logic          tick_o,
  output logic          osc_o,
  output logic          div_o
);

  localparam logic [CW-1:0] TOP  = '1;
  localparam logic [CW-1:0] MID  = {1'b1, {(CW-1){1'b0}}};
  localparam int            DW   = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(DIV - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] load;
  logic [DW-1:0] dcnt;

  assign tick_o = (cnt == TOP);
  assign load   = (ctrl_word == TOP) ? TOP - CW'(1) : ctrl_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= MID;
      osc_o <= 1'b0;
      dcnt  <= '0;
      div_o <= 1'b0;
    end else if (tick_o) begin
      cnt   <= load;
      osc_o <= ~osc_o;
      if (dcnt == LAST) begin
        dcnt  <= '0;
        div_o <= ~div_o;
      end else begin
        dcnt <= dcnt + DW'(1);
      end
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

  // R3
  single_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);

  // R5
  clamp_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && ctrl_word == TOP) |=> !tick_o ##1 tick_o);

  // R6
  osc_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> (osc_o != $past(osc_o)));

  // R6
  osc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_o |=> $stable(osc_o));

  // R7
  div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_o |=> $stable(div_o));

endmodule

// File: tb/sim_dco_reload.sv
module sim_dco_reload;
  localparam int CW  = 6;
  localparam int DIV = 3;
  localparam int NI  = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] ctrl_word = '0;
  logic          tick_o, osc_o, div_o;

  always #2 clk = ~clk;

  dco_reload #(.CW(CW), .DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word),
    .tick_o(tick_o), .osc_o(osc_o), .div_o(div_o)
  );

  int runs = 0, fails = 0;
  int expq[$];
  bit finished = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    runs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int period_of(int c);
    return (c == (1 << CW) - 1) ? 2 : (1 << CW) - c;
  endfunction

  int codes[NI] = '{32, 0, 63, 62, 60, 63, 10, 48, 1, 63, 63, 40};
  bit early[NI] = '{1, 1, 0, 0, 1, 0, 1, 0, 1, 0, 0, 1};

  // monitor: pops expected periods from the scoreboard and checks outputs
  int cyc = 0, last = -1, nev = 0;
  bit prev_tick = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      cyc = 0; last = -1; nev = 0; prev_tick = 0;
    end else if (!finished) begin
      cyc++;
      chk(osc_o == nev[0], "R6 osc level", osc_o, nev[0]);
      chk(div_o == ((nev / DIV) % 2), "R7 div level", div_o, (nev / DIV) % 2);
      if (prev_tick) chk(!tick_o, "R3 pulse width", tick_o, 0);
      if (tick_o) begin
        if (expq.size() > 0) begin
          int e;
          e = expq.pop_front();
          chk(cyc - last == e, "R1/R2/R4/R5/R8 period", cyc - last, e);
        end
        last = cyc;
        nev++;
      end
      prev_tick = tick_o;
    end
  end

  // driver
  initial begin
    repeat (3) @(negedge clk);
    chk(tick_o == 0, "R1 reset tick", tick_o, 0);
    chk(osc_o == 0, "R1 reset osc", osc_o, 0);
    chk(div_o == 0, "R1 reset div", div_o, 0);
    ctrl_word = 6'd20;
    expq.push_back(1 << (CW - 1));   // R1 first period from centre code
    #1 rst_n = 1'b1;
    for (int i = 0; i < NI; i++) begin
      do @(negedge clk); while (!tick_o);
      ctrl_word = CW'(codes[i]);
      expq.push_back(period_of(codes[i]));   // R2 R5 R8
      if (early[i]) begin
        // R4: next word presented mid-period must not shorten this period
        repeat (2) @(negedge clk);
        ctrl_word = CW'(codes[(i + 1) % NI]);
      end
    end
    while (expq.size() > 0) @(negedge clk);
    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      runs++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", expq.size(), 0);
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end
endmodule